// File: doc/BRIEF.md
# Pin I/O controller with edge-event interrupts

This block is a register-mapped general-purpose pin controller for 28 pins. Software reads the synchronised level of every pin and chooses each pin's direction. It changes output values through two write-only strobe registers: one forces bits high and the other forces bits low, so a pin can be changed without a read-modify-write of the output state. A further register holds an alternate-function choice for each pin. The block only stores that choice and brings it out on a port; it does no muxing.

Each pin has its own rising-edge enable and falling-edge enable. An enabled transition on the synchronised pin sets a sticky event bit. The bit stays set until software writes a one to it. Event bits 0 to 10 each drive their own interrupt line. Event bits 11 to 27 are ORed onto one shared line. Pin inputs pass through a two-flop synchroniser before they reach the level register and the edge logic. Pad buffers, wake-up logic and the bus fabric sit outside this block.

Top module: `pinio_edge_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero. pin_dir, pin_out, alt_sel, irq_pin and irq_shared are all zero.
- R2: A read of byte offset 0x00 returns the pin inputs after two clock edges of synchronisation, whatever each pin's direction. Data bits 31:28 of every read are zero.
- R3: Offset 0x04 is the direction register, with one bit per pin (1 = output, 0 = input). It is read/write, and pin_dir shows its value from the cycle after the write.
- R4: Writing offset 0x08 sets pin_out for each data bit that is 1 and leaves the bits written as 0 unchanged. A read of 0x08 returns zero.
- R5: Writing offset 0x0C clears pin_out for each data bit that is 1 and leaves the bits written as 0 unchanged. A read of 0x0C returns zero.
- R6: A 0-to-1 change of a synchronised pin sets that pin's bit in the event register (offset 0x18) when its bit in the rising-enable register (offset 0x10) is 1.
- R7: A 1-to-0 change sets the event bit when the pin's bit in the falling-enable register (offset 0x14) is 1. With both enables set, either change sets it.
- R8: A pin change on a pin whose two enable bits are both 0 leaves the event register unchanged.
- R9: Event bits stay set until a write to offset 0x18 has a 1 in that bit position. Zero bits in the write have no effect, and a write of all ones clears every pending bit.
- R10: When an enabled edge and a write-one-to-clear of the same bit fall in the same cycle, the bit stays set.
- R11: irq_pin[i] equals event bit i for i = 0 to 10. irq_shared is the OR of event bits 11 to 27.
- R12: Offset 0x1C is a read/write alternate-function register, one bit per pin, that appears on alt_sel. Writing it changes no other register.
- R13: A write to the level register at offset 0x00 has no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 28 | Asynchronous pin levels |
| pin_out | output | 28 | Output latch values |
| pin_dir | output | 28 | Direction per pin, 1 = output |
| alt_sel | output | 28 | Stored alternate-function selection |
| irq_pin | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt for pins 11 to 27 |

## Verification
The bench builds the block with its default parameters: 28 pins, 11 dedicated interrupt lines, a two-stage synchroniser, a 5-bit byte address and 32-bit data. With these values the 4 unused data bits above the pins, the boundary between pin 10 and pin 11, and the full 17-bit shared interrupt group can all be exercised. The two-cycle synchroniser latency is short enough to hit exactly, so the bench can make an enabled edge land in the same cycle as a clear write.

// File: rtl/pinio_pkg.sv
// Shared definitions for the pin I/O controller.
// Assumes 32-bit word registers, selected by byte address bits [4:2].
package pinio_pkg;

    // Register selector taken from byte address bits [4:2]
    typedef enum logic [2:0] {
        IDX_LEVEL = 3'd0,
        IDX_DIR   = 3'd1,
        IDX_SET   = 3'd2,
        IDX_CLR   = 3'd3,
        IDX_RISE  = 3'd4,
        IDX_FALL  = 3'd5,
        IDX_STAT  = 3'd6,
        IDX_ALT   = 3'd7
    } reg_idx_e;

    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned IDX_W   = 3;

endpackage

// File: rtl/pinio_sync.sv
// Multi-stage synchroniser, one chain per pin.
// Assumes every pin_in bit is asynchronous and can be sampled on its own;
// no bus-coherence between pins is promised.
module pinio_sync #(
    parameter int unsigned W      = 28,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= async_in;
                end
            end else begin : g_next
                // Later stages settle any metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/pinio_edge_det.sv
// Edge detector and sticky event register.
// Assumes level is already synchronous. An edge is the difference between
// this cycle's level and last cycle's. If a set and a clear of one bit land
// in the same cycle, the set wins.
module pinio_edge_det #(
    parameter int unsigned W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] edge_hit,
    output logic [W-1:0] status
);

    logic [W-1:0] prev;

    // Remember the previous synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= level;
    end

    // Keep only the transitions that are enabled
    always_comb begin
        edge_hit = (level & ~prev & rise_en) | (~level & prev & fall_en);
    end

    // Sticky status: clear by mask, then OR in new edges (new edges win)
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | edge_hit;
    end

endmodule

// File: rtl/pinio_regs.sv
// Register file and read mux for the pin controller.
// Assumes at most one write per cycle. Reads are combinational from bus_idx.
// The set and clear strobes act on the output latch and read back as zero.
module pinio_regs
    import pinio_pkg::*;
#(
    parameter int unsigned W      = 28,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic              bus_we,
    input  logic [W-1:0]      wr_bits,
    input  logic [W-1:0]      level,
    input  logic [W-1:0]      status,
    output logic [DATA_W-1:0] rdata,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      rise_q,
    output logic [W-1:0]      fall_q,
    output logic [W-1:0]      alt_q,
    output logic [W-1:0]      clr_mask
);

    localparam int unsigned PAD_W = DATA_W - W;

    reg_idx_e     idx;
    logic [W-1:0] rd_bits;

    assign idx = reg_idx_e'(bus_idx);

    // Plain read/write configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            alt_q  <= '0;
        end else if (bus_we) begin
            case (idx)
                IDX_DIR:  dir_q  <= wr_bits;
                IDX_RISE: rise_q <= wr_bits;
                IDX_FALL: fall_q <= wr_bits;
                IDX_ALT:  alt_q  <= wr_bits;
                default:  ;
            endcase
        end
    end

    // Output latch driven only by the set and clear strobes
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else if (bus_we && idx == IDX_SET) out_q <= out_q | wr_bits;
        else if (bus_we && idx == IDX_CLR) out_q <= out_q & ~wr_bits;
    end

    // Write-one-to-clear mask handed to the event register
    always_comb begin
        clr_mask = (bus_we && idx == IDX_STAT) ? wr_bits : '0;
    end

    // Read mux; strobe registers return zero
    always_comb begin
        case (idx)
            IDX_LEVEL: rd_bits = level;
            IDX_DIR:   rd_bits = dir_q;
            IDX_RISE:  rd_bits = rise_q;
            IDX_FALL:  rd_bits = fall_q;
            IDX_STAT:  rd_bits = status;
            IDX_ALT:   rd_bits = alt_q;
            default:   rd_bits = '0;
        endcase
        rdata = {{PAD_W{1'b0}}, rd_bits};
    end

endmodule

// File: rtl/pinio_irq_split.sv
// Interrupt fan-out: the low pins get their own lines, the rest share one.
// Assumes 0 < NDED < W.
module pinio_irq_split #(
    parameter int unsigned W    = 28,
    parameter int unsigned NDED = 11
) (
    input  logic [W-1:0]    status,
    output logic [NDED-1:0] irq_ded,
    output logic            irq_grp
);

    generate
        for (genvar i = 0; i < NDED; i++) begin : g_ded
            // One dedicated line per low pin
            assign irq_ded[i] = status[i];
        end
    endgenerate

    // OR of every pin above the dedicated range
    assign irq_grp = |status[W-1:NDED];

endmodule

// File: rtl/pinio_edge_ctrl.sv
// Top of the pin I/O controller: synchroniser, register file,
// edge detector and interrupt split.
// Assumes a single-cycle register bus with no wait states, and a
// synchronous active-low reset.
module pinio_edge_ctrl
    import pinio_pkg::*;
#(
    parameter int unsigned NPINS   = 28,
    parameter int unsigned NDED    = 11,
    parameter int unsigned SYNC_ST = 2,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_dir,
    output logic [NPINS-1:0]  alt_sel,
    output logic [NDED-1:0]   irq_pin,
    output logic              irq_shared
);

    logic [NPINS-1:0] level, rise_q, fall_q, clr_mask, edge_hit, edge_stat;
    logic             unused_bits;

    // Byte-lane bits and data bits above the pins are not decoded
    assign unused_bits = ^{bus_wdata[DATA_W-1:NPINS], bus_addr[IDX_LSB-1:0]};

    pinio_sync #(.W(NPINS), .STAGES(SYNC_ST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (level)
    );

    pinio_regs #(.W(NPINS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_idx  (bus_addr[IDX_LSB+IDX_W-1:IDX_LSB]),
        .bus_we   (bus_we),
        .wr_bits  (bus_wdata[NPINS-1:0]),
        .level    (level),
        .status   (edge_stat),
        .rdata    (bus_rdata),
        .dir_q    (pin_dir),
        .out_q    (pin_out),
        .rise_q   (rise_q),
        .fall_q   (fall_q),
        .alt_q    (alt_sel),
        .clr_mask (clr_mask)
    );

    pinio_edge_det #(.W(NPINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .clr_mask (clr_mask),
        .edge_hit (edge_hit),
        .status   (edge_stat)
    );

    pinio_irq_split #(.W(NPINS), .NDED(NDED)) u_irq (
        .status  (edge_stat),
        .irq_ded (irq_pin),
        .irq_grp (irq_shared)
    );

endmodule

// File: rtl/pinio_edge_ctrl_chk.sv
// Checker for the pin I/O controller, bound into the top.
// Assumes the bus is sampled on the same clock edge as the design.
module pinio_edge_ctrl_chk
    import pinio_pkg::*;
#(
    parameter int unsigned NPINS = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] bus_idx,
    input logic             bus_we,
    input logic [NPINS-1:0] wr_bits,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_dir,
    input logic [NPINS-1:0] edge_hit,
    input logic [NPINS-1:0] edge_stat
);

    logic [NPINS-1:0] w1c;

    // Clear mask rebuilt from the bus, independent of the register file
    assign w1c = (bus_we && bus_idx == IDX_STAT) ? wr_bits : '0;

    // R1: reset leaves the outputs idle
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_dir == '0 && edge_stat == '0));

    // R3: direction follows a direction write
    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_DIR) |=> pin_dir == $past(wr_bits));

    // R4: set strobe raises every written one
    p_set_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_SET) |=>
            ((pin_out & $past(wr_bits)) == $past(wr_bits)));

    // R5: clear strobe lowers every written one
    p_clr_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_CLR) |=> ((pin_out & $past(wr_bits)) == '0));

    // R6: a newly set event bit needs an enabled edge in the prior cycle
    p_new_from_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_stat & ~$past(edge_stat) & ~$past(edge_hit)) == '0));

    // R9: a pending bit survives unless written with a one
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_stat) & ~$past(w1c) & ~edge_stat) == '0));

    // R10: an edge in a clear cycle leaves the bit set
    p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_hit) & ~edge_stat) == '0));

endmodule

bind pinio_edge_ctrl pinio_edge_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_idx   (bus_addr[pinio_pkg::IDX_LSB+pinio_pkg::IDX_W-1:pinio_pkg::IDX_LSB]),
    .bus_we    (bus_we),
    .wr_bits   (bus_wdata[NPINS-1:0]),
    .pin_out   (pin_out),
    .pin_dir   (pin_dir),
    .edge_hit  (edge_hit),
    .edge_stat (edge_stat)
);

// File: tb/pinio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module pinio_edge_ctrl_bench;

    localparam int unsigned NP   = 28;
    localparam int unsigned ND   = 11;
    localparam logic [31:0] MASK = 32'h0FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_in, pin_out, pin_dir, alt_sel;
    logic [ND-1:0] irq_pin;
    logic        irq_shared;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model of the programmable state
    logic [NP-1:0] m_dir, m_out, m_rise, m_fall, m_stat, m_alt;

    pinio_edge_ctrl u_pinio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_dir(pin_dir), .alt_sel(alt_sel),
        .irq_pin(irq_pin), .irq_shared(irq_shared)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] edges(input logic [NP-1:0] o, input logic [NP-1:0] n,
                                            input logic [NP-1:0] re, input logic [NP-1:0] fe);
        return (n & ~o & re) | (~n & o & fe);
    endfunction

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr = {idx, 2'b00}; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        @(negedge clk);
        bus_addr = {idx, 2'b00};
        #0.5 v = bus_rdata;
    endtask

    task automatic move_pins(input logic [NP-1:0] n);
        @(negedge clk);
        m_stat |= edges(pin_in, n, m_rise, m_fall);
        pin_in = n;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(3'd0, v); check({tag, " R2 level"}, v, {4'h0, pin_in});
        rd(3'd1, v); check({tag, " R3 dir"},   v, {4'h0, m_dir});
        rd(3'd2, v); check({tag, " R4 set reads 0"}, v, 32'h0);
        rd(3'd3, v); check({tag, " R5 clr reads 0"}, v, 32'h0);
        rd(3'd4, v); check({tag, " R6 rise en"}, v, {4'h0, m_rise});
        rd(3'd5, v); check({tag, " R7 fall en"}, v, {4'h0, m_fall});
        rd(3'd6, v); check({tag, " R9 status"}, v, {4'h0, m_stat});
        rd(3'd7, v); check({tag, " R12 alt"},  v, {4'h0, m_alt});
        check({tag, " R3 pin_dir"}, 32'(pin_dir), 32'(m_dir));
        check({tag, " R4 pin_out"}, 32'(pin_out), 32'(m_out));
        check({tag, " R12 alt_sel"}, 32'(alt_sel), 32'(m_alt));
        check({tag, " R11 irq_pin"}, 32'(irq_pin), 32'(m_stat[ND-1:0]));
        check({tag, " R11 irq_shared"}, 32'(irq_shared), 32'(|m_stat[NP-1:ND]));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, d;
        logic [NP-1:0] np;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
        {m_dir, m_out, m_rise, m_fall, m_stat, m_alt} = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_all("reset R1");

        // R2: two-edge latency on the level register
        @(negedge clk);
        bus_addr = 5'h00;
        pin_in = 28'hA5A_5A5A;
        @(posedge clk); #0.5 check("R2 level after one edge", bus_rdata, 32'h0);
        @(posedge clk); #0.5 check("R2 level after two edges", bus_rdata, 32'h0A5A_5A5A);
        repeat (2) @(negedge clk);
        // R8: no enables, no events
        rd(3'd6, v); check("R8 no enable no event", v, 32'h0);

        // R2 with all pins as outputs: level still shows the inputs
        wr(3'd1, 32'hFFFF_FFFF); m_dir = '1;
        wr(3'd2, 32'h0000_FFFF); m_out = 28'h000_FFFF;
        check_all("outputs R2 R3 R4");

        // R5: clear some bits, zeros untouched
        wr(3'd3, 32'h0000_0F0F); m_out &= ~28'h000_0F0F;
        check("R5 clear strobe", 32'(pin_out), 32'h0000_F0F0);

        // R13: write to level register ignored
        wr(3'd0, 32'hFFFF_FFFF);
        check_all("level write R13");

        // R6/R7: rise on pin 3, fall on pin 12, both on pin 20
        wr(3'd4, 32'h0010_0008); m_rise = 28'h010_0008;
        wr(3'd5, 32'h0010_1000); m_fall = 28'h010_1000;
        move_pins(28'h0);
        check("R7 fall pin 12 event", 32'(irq_shared), 32'h1);
        move_pins(28'h010_0008);
        check("R6 rise pin 3 event", 32'(irq_pin[3]), 32'h1);
        check_all("edges R6 R7 R11");
        move_pins(28'h000_0008);
        check("R7 both edges pin 20", 32'(m_stat[20]), 32'h1);

        // R9: zero bits no effect, then all ones clear all
        wr(3'd6, 32'h0); check_all("w1c zero R9");
        wr(3'd6, 32'hFFFF_FFFF); m_stat = '0;
        check_all("w1c all R9");

        // R10: edge and clear in the same cycle
        wr(3'd4, 32'h0000_0020); m_rise = 28'h20;
        wr(3'd5, 32'h0);         m_fall = '0;
        move_pins(28'h0);
        @(negedge clk);
        pin_in = 28'h20;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 5'h18; bus_we = 1'b1; bus_wdata = 32'h20;
        @(negedge clk);
        bus_we = 1'b0;
        m_stat = 28'h20;
        check("R10 edge wins over clear", 32'(irq_pin[5]), 32'h1);
        check_all("collide R10");
        wr(3'd6, 32'h20); m_stat = '0;
        check("R9 later clear works", 32'(irq_pin[5]), 32'h0);

        // Random mix of register writes and pin moves
        for (int it = 0; it < 400; it++) begin
            d = $urandom;
            case ($urandom % 8)
                0: begin wr(3'd1, d); m_dir = d[NP-1:0]; end
                1: begin wr(3'd2, d); m_out |= d[NP-1:0]; end
                2: begin wr(3'd3, d); m_out &= ~d[NP-1:0]; end
                3: begin wr(3'd4, d); m_rise = d[NP-1:0]; end
                4: begin wr(3'd5, d); m_fall = d[NP-1:0]; end
                5: begin wr(3'd6, d & $urandom); m_stat &= ~(d[NP-1:0] & bus_wdata[NP-1:0]); end
                6: begin wr(3'd7, d); m_alt = d[NP-1:0]; end
                default: begin
                    np = d[NP-1:0] ^ ($urandom % 2 ? pin_in : '0);
                    move_pins(np);
                end
            endcase
            if (it % 20 == 19) check_all("random R8");
            else begin
                check("random R4 R5 pin_out", 32'(pin_out), 32'(m_out));
                check("random R11 irq_pin", 32'(irq_pin), 32'(m_stat[ND-1:0]));
                check("random R11 irq_shared", 32'(irq_shared), 32'(|m_stat[NP-1:ND]));
            end
        end

        wr(3'd6, 32'hFFFF_FFFF); m_stat = '0;
        check_all("final R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule